// File: doc/BRIEF.md
# Nine-Bit Host Write Assembler

This block sits at the host side of a display controller and accepts writes over a nine-line parallel bus. Each full-width word arrives as two back-to-back transfers, with the upper part sent first. The block puts the two parts together in the system clock domain. A register-select line decides what a pair of transfers means. When it is low, the pair is an index or instruction code: the lowest bus line is dropped from each transfer, which leaves two 8-bit halves of a 16-bit code. When it is high, the pair is pixel data: all nine lines are kept, which gives an 18-bit word.

Two host strobe styles are supported, and a 4-bit mode code picks between them. The first is an enable strobe qualified by a read/write line. The second is a separate active-low write strobe. All host-side inputs are asynchronous. They pass through a synchroniser before edge detection, and data and register-select are taken on the detected strobe edge. A completed word is presented together with a single-cycle valid pulse. The bus accepts writes only: read cycles are ignored.

Top module: `hostbus9_assembler`

## Requirements
- R1: A word completes only on the second of two transfers of the same kind. The first transfer after reset, after a cancel or after a completion is always taken as the upper part. An index write therefore also needs both transfers.
- R2: With `sel` = 0, the completed code is `{first[8:1], second[8:1]}` in `instr_word`. Line 0 of each transfer has no effect on the code.
- R3: With `sel` = 1, the completed value is `{first[8:0], second[8:0]}` in `data_word`. The first transfer supplies bits 17..9.
- R4: `mode_code` 4'b1001 selects enable-strobe style and 4'b1011 selects write-strobe style. Any other code accepts no transfers, keeps both valids low and clears any pending upper part.
- R5: In write-strobe style, a transfer is taken on the rising edge of `wr_n` while `cs_n` is low. The falling edge takes nothing.
- R6: In enable-strobe style, a transfer is taken on the falling edge of `en` while `rw` = 0 and `cs_n` is low. An `en` cycle with `rw` = 1 is a read. It is ignored and does not change the pending upper part.
- R7: When `cs_n` goes high, any pending upper part is dropped. The next transfer is then taken as an upper part.
- R8: If `sel` differs between a held upper part and the next transfer, that transfer becomes a new upper part and nothing completes.
- R9: `instr_valid` or `data_valid` is high for exactly one clock, never both at once. It rises in the third clock after the strobe edge. Each word output holds its value until its next completion.
- R10: During and after reset, both valids are low, both words are zero and no upper part is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_code | input | 4 | Interface mode code (static) |
| cs_n | input | 1 | Active-low chip select (async) |
| sel | input | 1 | Register select: 0 index/instruction, 1 pixel data (async) |
| wr_n | input | 1 | Active-low write strobe, write-strobe style (async) |
| en | input | 1 | Enable strobe, enable-strobe style (async) |
| rw | input | 1 | Read/write qualifier, 1 = read, enable-strobe style (async) |
| bus_d | input | 9 | Parallel data lines (async) |
| instr_valid | output | 1 | One-cycle pulse: instruction code complete |
| instr_word | output | 16 | Assembled instruction/index code |
| data_valid | output | 1 | One-cycle pulse: pixel word complete |
| data_word | output | 18 | Assembled pixel word |

## Verification
Some properties are checked by the assertions on every cycle:
- the two valid pulses are one clock long and never overlap;
- each completion follows a detected write edge that found an upper part of the same kind already held;
- chip select high clears the held half;
- an unsupported mode code keeps both outputs quiet;
- the words hold steady between completions.

Other behaviour can only be shown by the directed scenarios: the exact bit packing of each word kind, the three-clock latency, that the lowest line is dropped for codes, that read cycles leave the pairing untouched, and that a change of register select or a chip-select cancel restarts the pairing.

// File: rtl/hb9_pkg.sv
package hb9_pkg;
  localparam int BUS_W   = 9;
  localparam int INSTR_W = 2 * (BUS_W - 1);
  localparam int PIX_W   = 2 * BUS_W;

  localparam logic [3:0] MODE_ENABLE = 4'b1001;
  localparam logic [3:0] MODE_WRSTB  = 4'b1011;

  typedef enum logic [1:0] {
    STYLE_OFF   = 2'd0,
    STYLE_ENABLE = 2'd1,
    STYLE_WRSTB = 2'd2
  } bus_style_e;

  function automatic bus_style_e decode_mode(input logic [3:0] code);
    case (code)
      MODE_ENABLE: return STYLE_ENABLE;
      MODE_WRSTB:  return STYLE_WRSTB;
      default:     return STYLE_OFF;
    endcase
  endfunction

  function automatic logic mode_legal(input logic [3:0] code);
    return decode_mode(code) != STYLE_OFF;
  endfunction

  // code packing: the lowest line of each transfer is dropped
  function automatic logic [INSTR_W-1:0] pack_instr(input logic [BUS_W-1:0] hi,
                                                    input logic [BUS_W-1:0] lo);
    return {hi[BUS_W-1:1], lo[BUS_W-1:1]};
  endfunction

  // pixel packing: every line kept, first transfer on top
  function automatic logic [PIX_W-1:0] pack_pixel(input logic [BUS_W-1:0] hi,
                                                  input logic [BUS_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/hb9_sync.sv
module hb9_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hb9_strobe.sv
module hb9_strobe
  import hb9_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_style_e style,
  input  logic       cs_s,
  input  logic       wr_s,
  input  logic       en_s,
  input  logic       rw_s,
  output logic       wr_evt
);
  logic wr_q, en_q;
  logic wr_rise, en_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      en_q <= 1'b0;
    end else begin
      wr_q <= wr_s;
      en_q <= en_s;
    end
  end

  assign wr_rise = wr_s & ~wr_q;
  assign en_fall = ~en_s & en_q;

  always_comb begin
    case (style)
      STYLE_WRSTB:  wr_evt = wr_rise & ~cs_s;
      STYLE_ENABLE: wr_evt = en_fall & ~rw_s & ~cs_s;
      default:      wr_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/hb9_pairer.sv
module hb9_pairer
  import hb9_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cs_s,
  input  logic               wr_evt,
  input  logic               sel_s,
  input  logic [BUS_W-1:0]   d_s,
  output logic               held,
  output logic               instr_valid,
  output logic [INSTR_W-1:0] instr_word,
  output logic               data_valid,
  output logic [PIX_W-1:0]   data_word
);
  logic             up_sel;
  logic [BUS_W-1:0] up_d;
  logic             lower_hit;

  assign lower_hit = wr_evt & held & (sel_s == up_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held        <= 1'b0;
      up_sel      <= 1'b0;
      up_d        <= '0;
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
      instr_word  <= '0;
      data_word   <= '0;
    end else begin
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
      if (!enable || cs_s) begin
        held <= 1'b0;
      end else if (lower_hit) begin
        held <= 1'b0;
        if (sel_s) begin
          data_valid <= 1'b1;
          data_word  <= pack_pixel(up_d, d_s);
        end else begin
          instr_valid <= 1'b1;
          instr_word  <= pack_instr(up_d, d_s);
        end
      end else if (wr_evt) begin
        held   <= 1'b1;
        up_sel <= sel_s;
        up_d   <= d_s;
      end
    end
  end
endmodule

// File: rtl/hostbus9_assembler.sv
module hostbus9_assembler
  import hb9_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode_code,
  input  logic         cs_n,
  input  logic         sel,
  input  logic         wr_n,
  input  logic         en,
  input  logic         rw,
  input  logic [8:0]   bus_d,
  output logic         instr_valid,
  output logic [15:0]  instr_word,
  output logic         data_valid,
  output logic [17:0]  data_word
);
  localparam int CTRL_W = 5;
  localparam int VEC_W  = CTRL_W + BUS_W;
  localparam logic [VEC_W-1:0] VEC_RST = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, {BUS_W{1'b0}}};

  bus_style_e       style;
  logic [VEC_W-1:0] raw_vec, sync_vec;
  logic             cs_s, wr_s, en_s, rw_s, sel_s;
  logic [BUS_W-1:0] d_s;
  logic             wr_evt;
  logic             held;

  assign style   = decode_mode(mode_code);
  assign raw_vec = {cs_n, wr_n, en, rw, sel, bus_d};

  hb9_sync #(.W(VEC_W), .STAGES(SYNC_STAGES), .RST_VAL(VEC_RST)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_vec),
    .dout (sync_vec)
  );

  assign {cs_s, wr_s, en_s, rw_s, sel_s, d_s} = sync_vec;

  hb9_strobe strobe_i (
    .clk   (clk),
    .rst_n (rst_n),
    .style (style),
    .cs_s  (cs_s),
    .wr_s  (wr_s),
    .en_s  (en_s),
    .rw_s  (rw_s),
    .wr_evt(wr_evt)
  );

  hb9_pairer pairer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (style != STYLE_OFF),
    .cs_s       (cs_s),
    .wr_evt     (wr_evt),
    .sel_s      (sel_s),
    .d_s        (d_s),
    .held       (held),
    .instr_valid(instr_valid),
    .instr_word (instr_word),
    .data_valid (data_valid),
    .data_word  (data_word)
  );
endmodule

// File: rtl/hb9_checker.sv
module hb9_checker
  import hb9_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  mode_code,
  input logic        instr_valid,
  input logic [15:0] instr_word,
  input logic        data_valid,
  input logic [17:0] data_word,
  input logic        wr_evt,
  input logic        held,
  input logic        sel_s,
  input logic        cs_s
);
  // R9
  valid_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && data_valid));
  // R9
  instr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);
  // R9
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  // R9
  instr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> $stable(instr_word));
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(data_word));
  // R1
  instr_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> $past(wr_evt && held && !sel_s));
  // R1
  data_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(wr_evt && held && sel_s));
  // R7
  cs_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !held);
  // R4
  bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_legal(mode_code) && !mode_legal($past(mode_code))) |-> (!instr_valid && !data_valid));
endmodule

bind hostbus9_assembler hb9_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_code  (mode_code),
  .instr_valid(instr_valid),
  .instr_word (instr_word),
  .data_valid (data_valid),
  .data_word  (data_word),
  .wr_evt     (wr_evt),
  .held       (held),
  .sel_s      (sel_s),
  .cs_s       (cs_s)
);

// File: tb/hostbus9_assembler_tb.sv
module hostbus9_assembler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_code = 4'b1011;
  logic        cs_n = 1'b1;
  logic        sel = 1'b0;
  logic        wr_n = 1'b1;
  logic        en = 1'b0;
  logic        rw = 1'b0;
  logic [8:0]  bus_d = '0;
  logic        instr_valid, data_valid;
  logic [15:0] instr_word;
  logic [17:0] data_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit use_en_style = 1'b0;
  bit done = 1'b0;

  // window captures after each transfer
  logic        p_iv, p_dv, n_iv, n_dv;
  logic [15:0] p_iw;
  logic [17:0] p_dw;

  always #4 clk = ~clk;

  hostbus9_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .cs_n(cs_n), .sel(sel),
    .wr_n(wr_n), .en(en), .rw(rw), .bus_d(bus_d),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .data_valid(data_valid), .data_word(data_word)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_code(input logic [8:0] a, input logic [8:0] b);
    return 16'(((32'(a) >> 1) << 8) | (32'(b) >> 1));
  endfunction

  function automatic logic [17:0] exp_pix(input logic [8:0] a, input logic [8:0] b);
    return 18'((32'(a) << 9) | 32'(b));
  endfunction

  task automatic set_cs(input logic v);
    @(negedge clk); cs_n = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic s, input logic [8:0] d, input logic rd = 1'b0);
    @(negedge clk); sel = s; bus_d = d;
    repeat (2) @(negedge clk);
    if (use_en_style) begin
      rw = rd; en = 1'b1;
      repeat (2) @(negedge clk);
      en = 1'b0;
    end else begin
      wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    p_iv = instr_valid; p_dv = data_valid; p_iw = instr_word; p_dw = data_word;
    @(negedge clk);
    n_iv = instr_valid; n_dv = data_valid;
    rw = 1'b0;
  endtask

  task automatic expect_none(input string req);
    check(!p_iv && !p_dv && !n_iv && !n_dv, req, {p_iv, p_dv, n_iv, n_dv}, 0);
  endtask

  task automatic expect_code(input string req, input logic [15:0] e);
    check(p_iv && !p_dv, {req, " instr pulse"}, {p_iv, p_dv}, 2'b10);
    check(p_iw == e, {req, " code"}, p_iw, e);
    check(!n_iv && !n_dv, "R9 one-cycle pulse", {n_iv, n_dv}, 0);
  endtask

  task automatic expect_pix(input string req, input logic [17:0] e);
    check(p_dv && !p_iv, {req, " data pulse"}, {p_iv, p_dv}, 2'b01);
    check(p_dw == e, {req, " pixel"}, p_dw, e);
    check(!n_iv && !n_dv, "R9 one-cycle pulse", {n_iv, n_dv}, 0);
  endtask

  task automatic t_reset;
    // R10
    check(!instr_valid && !data_valid, "R10 valids low", {instr_valid, data_valid}, 0);
    check(instr_word == 0, "R10 code zero", instr_word, 0);
    check(data_word == 0, "R10 pixel zero", data_word, 0);
  endtask

  task automatic t_wrstb_code;
    use_en_style = 1'b0; mode_code = 4'b1011; set_cs(1'b0);
    xfer(1'b0, 9'h1A5);
    expect_none("R1 upper alone");
    xfer(1'b0, 9'h0F3);
    expect_code("R5 R2", exp_code(9'h1A5, 9'h0F3));
  endtask

  task automatic t_wrstb_pixel;
    xfer(1'b1, 9'h155);
    expect_none("R1 pixel upper alone");
    xfer(1'b1, 9'h0AA);
    expect_pix("R3", exp_pix(9'h155, 9'h0AA));
    check(p_iw == exp_code(9'h1A5, 9'h0F3), "R9 code held", p_iw, exp_code(9'h1A5, 9'h0F3));
  endtask

  task automatic t_lsb_ignored;
    xfer(1'b0, 9'h001);
    xfer(1'b0, 9'h001);
    expect_code("R2 line0 ignored", 16'h0000);
    xfer(1'b0, 9'h1FE);
    xfer(1'b0, 9'h1FF);
    expect_code("R2 line0 ignored", 16'hFFFF);
  endtask

  task automatic t_enable_style;
    set_cs(1'b1);
    use_en_style = 1'b1; mode_code = 4'b1001; set_cs(1'b0);
    xfer(1'b0, 9'h0C6);
    expect_none("R6 upper alone");
    xfer(1'b0, 9'h13B);
    expect_code("R6 R2", exp_code(9'h0C6, 9'h13B));
    xfer(1'b1, 9'h1FF);
    xfer(1'b1, 9'h000);
    expect_pix("R6 R3", exp_pix(9'h1FF, 9'h000));
  endtask

  task automatic t_read_ignored;
    xfer(1'b0, 9'h0A0);
    xfer(1'b0, 9'h155, 1'b1);
    expect_none("R6 read ignored");
    xfer(1'b0, 9'h00E);
    expect_code("R6 read keeps pairing", exp_code(9'h0A0, 9'h00E));
  endtask

  task automatic t_cs_cancel;
    xfer(1'b1, 9'h111);
    set_cs(1'b1);
    set_cs(1'b0);
    xfer(1'b1, 9'h022);
    expect_none("R7 cancel restarts");
    xfer(1'b1, 9'h033);
    expect_pix("R7", exp_pix(9'h022, 9'h033));
  endtask

  task automatic t_sel_change;
    xfer(1'b0, 9'h1C1);
    xfer(1'b1, 9'h0D2);
    expect_none("R8 sel change");
    xfer(1'b1, 9'h0E3);
    expect_pix("R8", exp_pix(9'h0D2, 9'h0E3));
  endtask

  task automatic t_bad_mode;
    xfer(1'b0, 9'h1AA);
    mode_code = 4'b1111;
    repeat (2) @(negedge clk);
    xfer(1'b0, 9'h055);
    xfer(1'b0, 9'h066);
    expect_none("R4 bad mode enable strobes");
    use_en_style = 1'b0; mode_code = 4'b1010;
    repeat (2) @(negedge clk);
    xfer(1'b1, 9'h077);
    xfer(1'b1, 9'h088);
    expect_none("R4 bad mode write strobes");
    mode_code = 4'b1011;
    repeat (2) @(negedge clk);
    xfer(1'b0, 9'h100);
    expect_none("R4 held half cleared");
    xfer(1'b0, 9'h0FF);
    expect_code("R4 recovery", exp_code(9'h100, 9'h0FF));
  endtask

  task automatic t_falling_ignored;
    // R5: a write strobe low with no rising edge takes nothing
    @(negedge clk); sel = 1'b0; bus_d = 9'h123; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    check(!instr_valid && !data_valid, "R5 falling edge ignored", {instr_valid, data_valid}, 0);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    xfer(1'b0, 9'h048);
    expect_code("R5 first rise was upper", exp_code(9'h123, 9'h048));
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wrstb_code();
    t_wrstb_pixel();
    t_lsb_ignored();
    t_falling_ignored();
    t_enable_style();
    t_read_ignored();
    t_cs_cancel();
    t_sel_change();
    t_bad_mode();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule